// File: doc/BRIEF.md
# Standard-Definition Raster Sync Generator

This block produces horizontal and vertical timing for standard-definition video from one pixel clock of 13.5 MHz. A two-bit scan selector picks one of four rasters: NTSC or PAL line and frame timing, each either interlaced or progressive. In the interlaced rasters the generator runs a frame of two fields, each half a line longer or shorter than a whole number of lines, and reports which field is being scanned on a field flag. The running pixel and line positions come out as well, so that downstream video logic can address the active picture.

The two syncs are active low and have registered outputs. A polarity control inverts both of them together. A direction control drives an output-enable that decides whether the board-level sync pins are driven or released so that they can act as inputs. A new scan selection is latched only when a frame ends, so a raster is never cut short halfway through.

Top module: `sd_raster_sync`

## Requirements
- R1: A line lasts NTSC_PIX (858) clocks when mode_i[1] is 0 and PAL_PIX (864) clocks when mode_i[1] is 1; pix_o counts 0 up to that length minus one and then returns to 0.
- R2: line_o counts lines of a frame and returns to 0 after the last one; a frame is 525 lines for mode 00 (NTSC interlaced), 263 for 01 (NTSC progressive), 625 for 10 (PAL interlaced) and 313 for 11 (PAL progressive).
- R3: HSYNC is active (low at polarity 0) for the first HS_W (64) pixels of every line, pixels 0 to HS_W-1, and inactive for the rest of the line.
- R4: VSYNC is active (low at polarity 0) for every pixel of lines 0 to VS_L-1 (VS_L = 3) of each frame, in all four modes.
- R5: In interlaced modes a second VSYNC starts at line (F-1)/2, pixel H/2 (F = frame lines, H = line length) and stays active for exactly VS_L lines, ending at pixel H/2 of line (F-1)/2+VS_L.
- R6: field_o is 0 from the start of a frame, goes to 1 at the second field start of R5 in interlaced modes, and stays 0 through the whole frame in progressive modes.
- R7: With pol_i at 1 both sync outputs are the inverse of their polarity-0 level, whatever the value of dir_i; a change of pol_i shows on the outputs one clock later.
- R8: oe_o follows dir_i one clock later (1 = sync pins driven, 0 = released as inputs); the syncs go on being generated while oe_o is 0.
- R9: A change of mode_i during a frame leaves the line length, frame length, second-field timing and field flag of the rest of that frame unchanged; the new mode applies from line 0, pixel 0 of the next frame.
- R10: While rst_i is high the outputs show pixel 0, line 0, field 0, both syncs active at the selected polarity, oe_o equal to dir_i, and the mode on mode_i is latched for the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 13.5 MHz pixel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Scan selector: 00 NTSC interlaced, 01 NTSC progressive, 10 PAL interlaced, 11 PAL progressive |
| dir_i | input | 1 | 1 drives the sync pins, 0 releases them |
| pol_i | input | 1 | 1 inverts both syncs |
| hsync_n_o | output | 1 | Horizontal sync, active low at polarity 0 |
| vsync_n_o | output | 1 | Vertical sync, active low at polarity 0 |
| oe_o | output | 1 | Output-enable for both sync pins |
| field_o | output | 1 | 0 in the first field, 1 in the second |
| pix_o | output | PW | Pixel position within the line |
| line_o | output | LW | Line position within the frame |

## Verification
The bench instantiates the generator with shortened lines and frames so that whole interlaced frames fit in the run, and it computes each expected level from the parameters. It probes the pixels on either side of every sync edge, above all the half-line start and end of the second-field VSYNC. A design off by one pixel there would move the field flag or cut the pulse short. It checks the last pixel of each frame type, where a wrong line count would wrap early or late. It switches modes in the middle of a frame to catch a generator that takes the new line length or interlace setting at once. It also flips polarity with the pins released to confirm that the inversion and the output-enable do not depend on each other.

// File: rtl/sd_raster_pkg.sv
package sd_raster_pkg;

  typedef enum logic [1:0] {
    SCAN_NTSC_I = 2'b00,
    SCAN_NTSC_P = 2'b01,
    SCAN_PAL_I  = 2'b10,
    SCAN_PAL_P  = 2'b11
  } scan_mode_e;

  function automatic logic is_pal(scan_mode_e m);
    return m[1];
  endfunction

  function automatic logic is_interlaced(scan_mode_e m);
    return !m[0];
  endfunction

  // last pixel index of a line
  function automatic int pix_last(scan_mode_e m, int np, int pp);
    return (is_pal(m) ? pp : np) - 1;
  endfunction

  // pixel where the second field begins
  function automatic int pix_half(scan_mode_e m, int np, int pp);
    return (is_pal(m) ? pp : np) / 2;
  endfunction

  // last line index of a frame (one field in progressive modes)
  function automatic int line_last(scan_mode_e m, int nf, int pf);
    int fr;
    fr = is_pal(m) ? pf : nf;
    return is_interlaced(m) ? fr - 1 : (fr + 1) / 2 - 1;
  endfunction

  // line where the second field begins
  function automatic int line_field1(scan_mode_e m, int nf, int pf);
    return ((is_pal(m) ? pf : nf) - 1) / 2;
  endfunction

endpackage

// File: rtl/sd_raster_counter.sv
module sd_raster_counter
  import sd_raster_pkg::*;
#(
  parameter int NTSC_PIX   = 858,
  parameter int PAL_PIX    = 864,
  parameter int NTSC_FRAME = 525,
  parameter int PAL_FRAME  = 625,
  parameter int PW         = 10,
  parameter int LW         = 10
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  scan_mode_e        mode_i,
  output logic [PW-1:0]     pix_q,
  output logic [LW-1:0]     line_q,
  output logic [PW-1:0]     nxt_pix,
  output logic [LW-1:0]     nxt_line,
  output scan_mode_e        nxt_mode
);

  scan_mode_e mode_q;
  logic       end_line;
  logic       end_frame;

  always_comb begin
    end_line  = (int'(pix_q) == pix_last(mode_q, NTSC_PIX, PAL_PIX));
    end_frame = end_line && (int'(line_q) == line_last(mode_q, NTSC_FRAME, PAL_FRAME));
    nxt_pix   = end_line ? '0 : pix_q + 1'b1;
    if (end_frame)     nxt_line = '0;
    else if (end_line) nxt_line = line_q + 1'b1;
    else               nxt_line = line_q;
    nxt_mode  = end_frame ? mode_i : mode_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pix_q  <= '0;
      line_q <= '0;
      mode_q <= mode_i;
    end else begin
      pix_q  <= nxt_pix;
      line_q <= nxt_line;
      mode_q <= nxt_mode;
    end
  end

endmodule

// File: rtl/sd_raster_decode.sv
module sd_raster_decode
  import sd_raster_pkg::*;
#(
  parameter int NTSC_PIX   = 858,
  parameter int PAL_PIX    = 864,
  parameter int NTSC_FRAME = 525,
  parameter int PAL_FRAME  = 625,
  parameter int HS_W       = 64,
  parameter int VS_L       = 3,
  parameter int PW         = 10,
  parameter int LW         = 10
) (
  input  logic [PW-1:0] pix_i,
  input  logic [LW-1:0] line_i,
  input  scan_mode_e    mode_i,
  output logic          hs_act_o,
  output logic          vs_act_o,
  output logic          fld_set_o,
  output logic          fld_clr_o
);

  int   p, l, h, f;
  logic inter;
  logic vs_second;

  always_comb begin
    p     = int'(pix_i);
    l     = int'(line_i);
    h     = pix_half(mode_i, NTSC_PIX, PAL_PIX);
    f     = line_field1(mode_i, NTSC_FRAME, PAL_FRAME);
    inter = is_interlaced(mode_i);

    // second-field pulse: from half line f to half line f+VS_L
    vs_second = inter && (((l == f) && (p >= h)) ||
                          ((l > f) && (l < f + VS_L)) ||
                          ((l == f + VS_L) && (p < h)));

    hs_act_o  = (p < HS_W);
    vs_act_o  = (l < VS_L) || vs_second;
    fld_set_o = inter && (l == f) && (p == h);
    fld_clr_o = (l == 0) && (p == 0);
  end

endmodule

// File: rtl/sd_raster_sync.sv
module sd_raster_sync
  import sd_raster_pkg::*;
#(
  parameter int NTSC_PIX   = 858,
  parameter int PAL_PIX    = 864,
  parameter int NTSC_FRAME = 525,
  parameter int PAL_FRAME  = 625,
  parameter int HS_W       = 64,
  parameter int VS_L       = 3,
  localparam int MAX_PIX   = (NTSC_PIX > PAL_PIX) ? NTSC_PIX : PAL_PIX,
  localparam int MAX_FRAME = (NTSC_FRAME > PAL_FRAME) ? NTSC_FRAME : PAL_FRAME,
  localparam int PW        = $clog2(MAX_PIX),
  localparam int LW        = $clog2(MAX_FRAME)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [1:0]    mode_i,
  input  logic          dir_i,
  input  logic          pol_i,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic          oe_o,
  output logic          field_o,
  output logic [PW-1:0] pix_o,
  output logic [LW-1:0] line_o
);

  logic [PW-1:0] pix_q, nxt_pix;
  logic [LW-1:0] line_q, nxt_line;
  scan_mode_e    nxt_mode;
  logic          hs_act, vs_act, fld_set, fld_clr;

  sd_raster_counter #(
    .NTSC_PIX(NTSC_PIX), .PAL_PIX(PAL_PIX),
    .NTSC_FRAME(NTSC_FRAME), .PAL_FRAME(PAL_FRAME),
    .PW(PW), .LW(LW)
  ) u_counter (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .mode_i   (scan_mode_e'(mode_i)),
    .pix_q    (pix_q),
    .line_q   (line_q),
    .nxt_pix  (nxt_pix),
    .nxt_line (nxt_line),
    .nxt_mode (nxt_mode)
  );

  // decode the position the counter moves to, so outputs line up with it
  sd_raster_decode #(
    .NTSC_PIX(NTSC_PIX), .PAL_PIX(PAL_PIX),
    .NTSC_FRAME(NTSC_FRAME), .PAL_FRAME(PAL_FRAME),
    .HS_W(HS_W), .VS_L(VS_L),
    .PW(PW), .LW(LW)
  ) u_decode (
    .pix_i     (nxt_pix),
    .line_i    (nxt_line),
    .mode_i    (nxt_mode),
    .hs_act_o  (hs_act),
    .vs_act_o  (vs_act),
    .fld_set_o (fld_set),
    .fld_clr_o (fld_clr)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hsync_n_o <= pol_i;
      vsync_n_o <= pol_i;
      field_o   <= 1'b0;
      oe_o      <= dir_i;
    end else begin
      hsync_n_o <= !hs_act ^ pol_i;
      vsync_n_o <= !vs_act ^ pol_i;
      oe_o      <= dir_i;
      if (fld_clr)      field_o <= 1'b0;
      else if (fld_set) field_o <= 1'b1;
    end
  end

  assign pix_o  = pix_q;
  assign line_o = line_q;

endmodule

// File: rtl/sd_raster_sync_chk.sv
module sd_raster_sync_chk #(
  parameter int NTSC_PIX   = 858,
  parameter int PAL_PIX    = 864,
  parameter int NTSC_FRAME = 525,
  parameter int PAL_FRAME  = 625,
  parameter int HS_W       = 64,
  parameter int VS_L       = 3,
  parameter int PW         = 10,
  parameter int LW         = 10
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          dir_i,
  input logic          pol_i,
  input logic          hsync_n_o,
  input logic          vsync_n_o,
  input logic          oe_o,
  input logic          field_o,
  input logic [PW-1:0] pix_o,
  input logic [LW-1:0] line_o
);

  // R1
  pix_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (pix_o != '0) |-> (int'(pix_o) == int'($past(pix_o)) + 1));

  // R1
  pix_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((pix_o == '0) && ($past(pix_o) != '0)) |->
      ((int'($past(pix_o)) == NTSC_PIX - 1) || (int'($past(pix_o)) == PAL_PIX - 1)));

  // R2
  frame_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((line_o == '0) && ($past(line_o) != '0)) |->
      ((int'($past(line_o)) == NTSC_FRAME - 1) || (int'($past(line_o)) == (NTSC_FRAME + 1) / 2 - 1) ||
       (int'($past(line_o)) == PAL_FRAME - 1)  || (int'($past(line_o)) == (PAL_FRAME + 1) / 2 - 1)));

  // R3
  hsync_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hsync_n_o ^ $past(pol_i)) == (int'(pix_o) >= HS_W));

  // R4
  vsync_top_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (int'(line_o) < VS_L) |-> !(vsync_n_o ^ $past(pol_i)));

  // R6
  field_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(field_o) |-> ((int'(pix_o) == NTSC_PIX / 2) || (int'(pix_o) == PAL_PIX / 2)));

  // R6
  field_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((line_o == '0) && (pix_o == '0)) |-> !field_o);

  // R8
  oe_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    oe_o == $past(dir_i));

endmodule

bind sd_raster_sync sd_raster_sync_chk #(
  .NTSC_PIX(NTSC_PIX), .PAL_PIX(PAL_PIX),
  .NTSC_FRAME(NTSC_FRAME), .PAL_FRAME(PAL_FRAME),
  .HS_W(HS_W), .VS_L(VS_L), .PW(PW), .LW(LW)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .dir_i     (dir_i),
  .pol_i     (pol_i),
  .hsync_n_o (hsync_n_o),
  .vsync_n_o (vsync_n_o),
  .oe_o      (oe_o),
  .field_o   (field_o),
  .pix_o     (pix_o),
  .line_o    (line_o)
);

// File: tb/sd_raster_sync_bench.sv
module sd_raster_sync_bench;

  // shortened raster so whole interlaced frames fit in the run
  localparam int NP = 58;
  localparam int PP = 64;
  localparam int NF = 25;
  localparam int PF = 31;
  localparam int HW = 8;
  localparam int VL = 3;
  localparam int PW = 6;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic          dir = 1'b1;
  logic          pol = 1'b0;
  logic          hs_n, vs_n, oe, fld;
  logic [PW-1:0] pix;
  logic [LW-1:0] line;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sd_raster_sync #(
    .NTSC_PIX(NP), .PAL_PIX(PP), .NTSC_FRAME(NF), .PAL_FRAME(PF),
    .HS_W(HW), .VS_L(VL)
  ) u_sd_raster_sync (
    .clk_i(clk), .rst_i(rst), .mode_i(mode), .dir_i(dir), .pol_i(pol),
    .hsync_n_o(hs_n), .vsync_n_o(vs_n), .oe_o(oe), .field_o(fld),
    .pix_o(pix), .line_o(line)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start(input logic [1:0] m, input logic p, input logic d);
    @(negedge clk);
    rst = 1'b1; mode = m; pol = p; dir = d;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode, line, pix, hsync_n, vsync_n, field (polarity 0)
  localparam int NV = 18;
  localparam int VEC [NV][6] = '{
    '{0,  0,  0, 0, 0, 0},   // R3 R4 start of frame
    '{0,  0,  7, 0, 0, 0},   // R3 last hsync pixel
    '{0,  0,  8, 1, 0, 0},   // R3 first idle pixel
    '{0,  2, 57, 1, 0, 0},   // R4 last vsync pixel, R1 last pixel
    '{0,  3,  0, 0, 1, 0},   // R4 vsync ends
    '{0, 12, 28, 1, 1, 0},   // R5 before half line
    '{0, 12, 29, 1, 0, 1},   // R5 R6 second field starts
    '{0, 15, 28, 1, 0, 1},   // R5 last pixel of second pulse
    '{0, 15, 29, 1, 1, 1},   // R5 pulse ends
    '{0, 24, 57, 1, 1, 1},   // R2 last pixel of frame
    '{1, 12, 29, 1, 1, 0},   // R6 progressive: no second field
    '{1, 12, 57, 1, 1, 0},   // R2 progressive last pixel
    '{2, 15, 31, 1, 1, 0},   // R5 PAL before half line
    '{2, 15, 32, 1, 0, 1},   // R5 R6 PAL second field
    '{2, 18, 31, 1, 0, 1},   // R5 PAL last pulse pixel
    '{2, 18, 32, 1, 1, 1},   // R5 PAL pulse ends
    '{2, 30, 63, 1, 1, 1},   // R1 R2 PAL last pixel
    '{3, 15, 63, 1, 1, 0}    // R2 PAL progressive last pixel
  };

  initial begin
    // table walk
    for (int i = 0; i < NV; i++) begin
      int h;
      h = (VEC[i][0] >= 2) ? PP : NP;
      start(2'(VEC[i][0]), 1'b0, 1'b1);
      step(VEC[i][1] * h + VEC[i][2]);
      chk("R1 pix", int'(pix), VEC[i][2]);
      chk("R2 line", int'(line), VEC[i][1]);
      chk("R3 hsync", int'(hs_n), VEC[i][3]);
      chk("R4/R5 vsync", int'(vs_n), VEC[i][4]);
      chk("R6 field", int'(fld), VEC[i][5]);
    end

    // R10 reset state
    start(2'b00, 1'b0, 1'b1);
    chk("R10 pix", int'(pix), 0);
    chk("R10 line", int'(line), 0);
    chk("R10 hsync", int'(hs_n), 0);
    chk("R10 vsync", int'(vs_n), 0);
    chk("R10 field", int'(fld), 0);
    chk("R10 oe", int'(oe), 1);

    // R2 interlaced frame wrap clears field
    step(NF * NP - 1);
    chk("R2 line before wrap", int'(line), NF - 1);
    chk("R6 field before wrap", int'(fld), 1);
    step(1);
    chk("R2 line after wrap", int'(line), 0);
    chk("R1 pix after wrap", int'(pix), 0);
    chk("R6 field after wrap", int'(fld), 0);

    // R2 progressive PAL wrap
    start(2'b11, 1'b0, 1'b1);
    step(((PF + 1) / 2) * PP);
    chk("R2 PAL progressive wrap line", int'(line), 0);
    chk("R4 PAL progressive vsync", int'(vs_n), 0);

    // R7 polarity with pins driven
    start(2'b00, 1'b1, 1'b1);
    chk("R7 inverted hsync at reset", int'(hs_n), 1);
    chk("R7 inverted vsync at reset", int'(vs_n), 1);
    step(HW);
    chk("R7 inverted idle hsync", int'(hs_n), 0);
    pol = 1'b0;
    step(1);
    chk("R7 normal hsync after pol change", int'(hs_n), 1);
    chk("R7 normal vsync after pol change", int'(vs_n), 0);

    // R7 R8 polarity with pins released
    start(2'b00, 1'b1, 1'b0);
    chk("R8 oe released", int'(oe), 0);
    chk("R7 inverted hsync released", int'(hs_n), 1);
    step(HW + 1);
    chk("R7 R8 syncs run while released", int'(hs_n), 0);
    dir = 1'b1;
    step(1);
    chk("R8 oe driven after one clock", int'(oe), 1);

    // R9 switch to interlaced mid-frame
    start(2'b01, 1'b0, 1'b1);
    step(100);
    mode = 2'b00;
    step(12 * NP + 29 - 100);
    chk("R9 field held in old progressive frame", int'(fld), 0);
    chk("R9 vsync idle in old progressive frame", int'(vs_n), 1);
    step(((NF + 1) / 2) * NP - (12 * NP + 29));
    chk("R9 wrap at old frame length", int'(line), 0);
    step(12 * NP + 29);
    chk("R9 second field in new mode", int'(fld), 1);
    chk("R9 second vsync in new mode", int'(vs_n), 0);

    // R9 switch to PAL mid-frame
    start(2'b01, 1'b0, 1'b1);
    step(100);
    mode = 2'b11;
    step(((NF + 1) / 2) * NP - 1 - 100);
    chk("R9 old line length kept pix", int'(pix), NP - 1);
    chk("R9 old line length kept line", int'(line), (NF + 1) / 2 - 1);
    step(1);
    chk("R9 frame boundary line", int'(line), 0);
    step(PP - 1);
    chk("R9 new line length pix", int'(pix), PP - 1);
    chk("R9 new line length line", int'(line), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule